// File: doc/BRIEF.md
# DMA Sample-Count Flow Controller

This block does the flow-control bookkeeping for one DMA channel that moves samples between a serial peripheral and a buffer memory. The processor core sends it single-cycle commands: a reset of the channel, an addition to the input sample count, and an addition to the output sample count. The DMA engine sends it one strobe for each sample moved. From these the block keeps a signed input counter and an unsigned output counter. It enables transfers in each direction and raises an input-buffer-full interrupt and an output-buffer-empty interrupt. Software uses these interrupts to hand logical buffers back and forth with the DMA engine.

The input counter starts at -1. An add-to-input command arms the channel and adds its parameter to the counter. Each input sample then counts the counter down. The buffer-full interrupt fires when the count drops from 0 to -1, and input transfers keep running after that. The output counter starts at 0 and counts down once per sample sent. Output transfers stop when this counter reaches zero, and the buffer-empty interrupt fires at that point. Output stays idle until the input side has been armed once since the last reset. A sticky range-error flag reports when a counter leaves its valid range, and from then on the buffer-full interrupt is held low.

Top module: `dma_flow_ctl`

## Requirements
- R1: After hardware reset, in_level reads -1, out_level reads 0, and in_en, out_en, in_full_irq, out_empty_irq and range_err are all 0.
- R2: cmd_op = 2'b10 (add-to-input) adds cmd_arg, read as 12-bit two's complement, to the input counter and sets in_en to 1. in_en stays set until a reset command.
- R3: in_strobe decrements the input counter by one only while in_en is 1. When in_en is 0, the strobe leaves in_level unchanged.
- R4: in_full_irq rises in the cycle after a decrement takes the input counter from 0 to -1. After that, further strobes keep decrementing the counter and in_en stays 1.
- R5: in_full_irq clears on an add-to-input command whose result is 0 or above. It stays set when the result is still negative.
- R6: cmd_op = 2'b11 (add-to-output) adds cmd_arg[10:0], read as unsigned, to the output counter. out_en is 1 only while in_en is 1 and out_level is non-zero. Each out_strobe taken while out_en is 1 decrements out_level.
- R7: When a decrement brings out_level to 0, out_empty_irq rises and out_en falls. Later out_strobe pulses leave out_level at 0.
- R8: out_empty_irq clears on an add-to-output command whose result is above zero. It stays set when the result is zero.
- R9: cmd_op = 2'b01 (reset) returns every output to the R1 state on the next cycle, whatever the strobes are doing in that cycle. This includes disarming in_en. cmd_op = 2'b00 is no command.
- R10: If the input counter would leave the range -1023 to +1024, or the output counter would exceed 1024, range_err sets. Once set, range_err stays set until a reset, and in_full_irq is held at 0 while it is set.
- R11: When a command and an accepted strobe act on the same counter in the same cycle, the counter becomes old value + parameter - 1. The interrupt rules of R4, R5, R7 and R8 are applied to that combined result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cmd_op | input | 2 | Command code: 00 none, 01 reset, 10 add-to-input, 11 add-to-output |
| cmd_arg | input | 12 | Command parameter (signed for input, low 11 bits unsigned for output) |
| in_strobe | input | 1 | One input sample moved into buffer memory |
| out_strobe | input | 1 | One output sample sent to the peripheral |
| in_en | output | 1 | Input transfers enabled |
| out_en | output | 1 | Output transfers enabled |
| in_full_irq | output | 1 | Input-buffer-full interrupt |
| out_empty_irq | output | 1 | Output-buffer-empty interrupt |
| range_err | output | 1 | Sticky counter range error |
| in_level | output | 12 | Input counter, two's complement |
| out_level | output | 11 | Output counter, unsigned |

## Verification
The assertions assume that cmd_op carries at most one command per cycle. They also assume that strobes arriving while a direction is disabled are harmless, so they only check that such strobes have no effect and never forbid them. The bench drives commands and strobes at the falling edge and keeps parameters small. Legal-range runs are therefore only left on purpose, in the range-error cases, and a reset command follows every such excursion. A mixed pseudo-random phase also issues reset commands at regular points, so long runs of additions cannot carry the counters into undefined territory without that being modelled.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
    typedef enum logic [1:0] {
        OP_NONE    = 2'b00,
        OP_RESET   = 2'b01,
        OP_ADD_IN  = 2'b10,
        OP_ADD_OUT = 2'b11
    } dfc_op_e;
endpackage

// File: rtl/dfc_in_track.sv
module dfc_in_track #(
    parameter int IW = 12,
    parameter int HI = 1024,
    parameter int LO = -1023
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 add_en,
    input  logic [IW-1:0]        add_val,
    input  logic                 dec_req,
    output logic [IW-1:0]        level_o,
    output logic                 armed_o,
    output logic                 full_o,
    output logic                 oob_o
);
    localparam int SW = IW + 2;
    localparam logic signed [SW-1:0] HI_W = SW'(HI);
    localparam logic signed [SW-1:0] LO_W = SW'(LO);

    typedef struct packed {
        logic [IW-1:0] lvl;
        logic          armed;
        logic          full;
    } in_st_t;

    in_st_t st_d, st_q;
    logic signed [SW-1:0] sum_w, nxt_w, cur_w, add_w;
    logic dec;

    always_comb begin
        dec   = dec_req & st_q.armed;
        cur_w = {{2{st_q.lvl[IW-1]}}, st_q.lvl};
        add_w = add_en ? {{2{add_val[IW-1]}}, add_val} : '0;
        sum_w = cur_w + add_w;
        nxt_w = sum_w - {{(SW-1){1'b0}}, dec};
        st_d  = st_q;
        oob_o = 1'b0;
        if (clr) begin
            st_d.lvl   = '1;
            st_d.armed = 1'b0;
            st_d.full  = 1'b0;
        end else begin
            st_d.lvl = nxt_w[IW-1:0];
            if (add_en) st_d.armed = 1'b1;
            if (dec && sum_w == '0)
                st_d.full = 1'b1;
            else if (add_en && !nxt_w[SW-1])
                st_d.full = 1'b0;
            oob_o = (nxt_w > HI_W) || (nxt_w < LO_W);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lvl   <= '1;
            st_q.armed <= 1'b0;
            st_q.full  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.lvl;
    assign armed_o = st_q.armed;
    assign full_o  = st_q.full;

    // R4: a lone accepted decrement from zero raises the full flag
    a_r4_full_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !add_en && dec_req && armed_o && level_o == '0) |=> full_o);

    // R3: a disarmed counter ignores strobes
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !add_en && !armed_o) |=> ($stable(level_o) && !armed_o));

    // R9: reset command restores initial state
    a_r9_clear_restores: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (level_o == '1 && !armed_o && !full_o));
endmodule

// File: rtl/dfc_out_track.sv
module dfc_out_track #(
    parameter int OW   = 11,
    parameter int OMAX = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          arm,
    input  logic          add_en,
    input  logic [OW-1:0] add_val,
    input  logic          dec_req,
    output logic [OW-1:0] level_o,
    output logic          en_o,
    output logic          empty_o,
    output logic          oob_o
);
    localparam int SW = OW + 2;
    localparam logic [SW-1:0] MAX_W = SW'(OMAX);
    localparam logic [SW-1:0] ONE_W = SW'(1);

    typedef struct packed {
        logic [OW-1:0] lvl;
        logic          empty;
    } out_st_t;

    out_st_t st_d, st_q;
    logic [SW-1:0] sum_w, nxt_w;
    logic dec;

    assign en_o = arm && (st_q.lvl != '0);

    always_comb begin
        dec   = dec_req & en_o;
        sum_w = {2'b00, st_q.lvl} + (add_en ? {2'b00, add_val} : '0);
        nxt_w = sum_w - {{(SW-1){1'b0}}, dec};
        st_d  = st_q;
        oob_o = 1'b0;
        if (clr) begin
            st_d.lvl   = '0;
            st_d.empty = 1'b0;
        end else begin
            st_d.lvl = nxt_w[OW-1:0];
            if (dec && sum_w == ONE_W)
                st_d.empty = 1'b1;
            else if (add_en && nxt_w != '0)
                st_d.empty = 1'b0;
            oob_o = nxt_w > MAX_W;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lvl   <= '0;
            st_q.empty <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.lvl;
    assign empty_o = st_q.empty;

    // R6: no output service before the input side is armed
    a_r6_no_out_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |-> !en_o);

    // R7: counter halts at zero without new credit
    a_r7_halt_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !add_en && level_o == '0) |=> level_o == '0);

    // R7: last sample raises empty
    a_r7_empty_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !add_en && en_o && dec_req && level_o == OW'(1)) |=> (empty_o && !en_o));
endmodule

// File: rtl/dma_flow_ctl.sv
module dma_flow_ctl #(
    parameter int IN_W    = 12,
    parameter int OUT_W   = 11,
    parameter int IN_HI   = 1024,
    parameter int IN_LO   = -1023,
    parameter int OUT_MAX = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cmd_op,
    input  logic [IN_W-1:0]  cmd_arg,
    input  logic             in_strobe,
    input  logic             out_strobe,
    output logic             in_en,
    output logic             out_en,
    output logic             in_full_irq,
    output logic             out_empty_irq,
    output logic             range_err,
    output logic [IN_W-1:0]  in_level,
    output logic [OUT_W-1:0] out_level
);
    import dfc_pkg::*;

    typedef struct packed {
        logic err;
    } top_st_t;

    top_st_t st_d, st_q;
    logic do_clr, do_add_in, do_add_out;
    logic in_oob, out_oob, armed, full_raw;

    always_comb begin
        do_clr     = cmd_op == OP_RESET;
        do_add_in  = cmd_op == OP_ADD_IN;
        do_add_out = cmd_op == OP_ADD_OUT;
    end

    dfc_in_track #(.IW(IN_W), .HI(IN_HI), .LO(IN_LO)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (do_clr),
        .add_en  (do_add_in),
        .add_val (cmd_arg),
        .dec_req (in_strobe),
        .level_o (in_level),
        .armed_o (armed),
        .full_o  (full_raw),
        .oob_o   (in_oob)
    );

    dfc_out_track #(.OW(OUT_W), .OMAX(OUT_MAX)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (do_clr),
        .arm     (armed),
        .add_en  (do_add_out),
        .add_val (cmd_arg[OUT_W-1:0]),
        .dec_req (out_strobe),
        .level_o (out_level),
        .en_o    (out_en),
        .empty_o (out_empty_irq),
        .oob_o   (out_oob)
    );

    always_comb begin
        st_d = st_q;
        if (do_clr)
            st_d.err = 1'b0;
        else if (in_oob || out_oob)
            st_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.err <= 1'b0;
        else        st_q     <= st_d;
    end

    assign range_err   = st_q.err;
    assign in_en       = armed;
    assign in_full_irq = full_raw & ~st_q.err;

    // R10: error is sticky until a reset command
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (range_err && cmd_op != OP_RESET) |=> range_err);

    // R10: full interrupt masked while in error
    a_r10_full_masked: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |-> !in_full_irq);

    // R6: output enable implies armed input side
    a_r6_out_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> in_en);
endmodule

// File: tb/dma_flow_ctl_bench.sv
module dma_flow_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [11:0] cmd_arg = '0;
    logic        in_strobe = 1'b0, out_strobe = 1'b0;
    logic        in_en, out_en, in_full_irq, out_empty_irq, range_err;
    logic [11:0] in_level;
    logic [10:0] out_level;

    int checks = 0, failures = 0;
    bit finished = 0;

    // expected model state
    int m_in, m_out;
    bit m_armed, m_full, m_empty, m_err;
    int unsigned lfsr = 32'h1234_5678;

    always #10 clk = ~clk;

    dma_flow_ctl u_dma_flow_ctl (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
        .in_strobe(in_strobe), .out_strobe(out_strobe),
        .in_en(in_en), .out_en(out_en), .in_full_irq(in_full_irq),
        .out_empty_irq(out_empty_irq), .range_err(range_err),
        .in_level(in_level), .out_level(out_level)
    );

    function automatic int wrap12(int v);
        int r = v & 4095;
        return (r >= 2048) ? r - 4096 : r;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        chk(req, "in_level", int'($signed(in_level)), m_in);
        chk(req, "out_level", int'(out_level), m_out);
        chk(req, "in_en", int'(in_en), int'(m_armed));
        chk(req, "out_en", int'(out_en), int'(m_armed && m_out != 0));
        chk(req, "in_full_irq", int'(in_full_irq), int'(m_full && !m_err));
        chk(req, "out_empty_irq", int'(out_empty_irq), int'(m_empty));
        chk(req, "range_err", int'(range_err), int'(m_err));
    endtask

    task automatic model_reset();
        m_in = -1; m_out = 0; m_armed = 0; m_full = 0; m_empty = 0; m_err = 0;
    endtask

    // one cycle: drive at falling edge, model update, sample at next falling edge
    task automatic step(input logic [1:0] op, input int arg, input bit ix, input bit ox, input string req);
        int sa, ua, si, ni, so, no;
        bit di, dox;
        cmd_op = op; cmd_arg = 12'(arg); in_strobe = ix; out_strobe = ox;
        if (op == 2'b01) begin
            model_reset();
        end else begin
            sa  = wrap12(arg);
            ua  = arg & 2047;
            di  = ix && m_armed;
            dox = ox && m_armed && m_out != 0;
            si  = m_in + ((op == 2'b10) ? sa : 0);
            ni  = si - int'(di);
            so  = m_out + ((op == 2'b11) ? ua : 0);
            no  = so - int'(dox);
            if (ni > 1024 || ni < -1023 || no > 1024) m_err = 1;
            if (di && si == 0) m_full = 1;
            else if (op == 2'b10 && ni >= 0) m_full = 0;
            if (dox && so == 1) m_empty = 1;
            else if (op == 2'b11 && no > 0) m_empty = 0;
            if (op == 2'b10) m_armed = 1;
            m_in  = wrap12(ni);
            m_out = no & 2047;
        end
        @(negedge clk);
        cmd_op = 2'b00; in_strobe = 0; out_strobe = 0;
        check_all(req);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R3: strobes ignored before arming; R6: output credit parked
        step(2'b00, 0, 1, 1, "R3");
        step(2'b11, 5, 0, 0, "R6");
        step(2'b00, 0, 1, 1, "R6");
        // R2: arm with 4
        step(2'b10, 4, 0, 0, "R2");
        // R4: count down through 0 -> -1 and beyond
        for (int i = 0; i < 7; i++) step(2'b00, 0, 1, 0, "R4");
        // R5: add leaving negative keeps full, non-negative clears
        step(2'b10, 2, 0, 0, "R5");
        step(2'b10, 10, 0, 0, "R5");
        // R7: drain output to zero, then extra strobes
        for (int i = 0; i < 8; i++) step(2'b00, 0, 0, 1, "R7");
        // R8: zero add keeps empty, positive add clears
        step(2'b11, 0, 0, 0, "R8");
        step(2'b11, 3, 0, 0, "R8");
        // R11: combined add and decrement
        step(2'b10, 12'hFF6, 1, 0, "R11");  // -10 with strobe
        step(2'b10, 1, 1, 0, "R11");
        step(2'b11, 1, 0, 1, "R11");
        step(2'b11, 0, 0, 1, "R11");
        // R9: reset command with strobes active
        step(2'b01, 0, 1, 1, "R9");
        // R10: input overflow, full masked, reset clears
        step(2'b10, 1030, 0, 0, "R10");
        for (int i = 0; i < 3; i++) step(2'b00, 0, 1, 0, "R10");
        step(2'b01, 0, 0, 0, "R10");
        step(2'b10, 12'hC00, 0, 0, "R10");  // -1024 underflow
        step(2'b01, 0, 0, 0, "R10");
        step(2'b11, 1025, 0, 0, "R10");
        step(2'b01, 0, 0, 0, "R10");

        // sweep: each buffer size, count through the wrap point (R4, R5)
        for (int n = 0; n <= 16; n++) begin
            step(2'b01, 0, 0, 0, "R9");
            step(2'b10, n, 0, 0, "R2");
            step(2'b11, n, 0, 0, "R6");
            for (int k = 0; k < n + 3; k++) step(2'b00, 0, 1, 1, "R4");
            step(2'b10, n, 0, 0, "R5");
        end

        // mixed pseudo-random traffic (R11 and all rules)
        for (int t = 0; t < 4000; t++) begin
            int r, op_sel;
            logic [1:0] op;
            int arg;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            r = int'(lfsr & 32'h7FFF_FFFF);
            op_sel = r % 8;
            arg = 0;
            if ((t % 64) == 63)  op = 2'b01;
            else if (op_sel == 4) begin op = 2'b10; arg = ((r >> 4) % 17) - 6; end
            else if (op_sel == 5) begin op = 2'b11; arg = (r >> 4) % 9; end
            else op = 2'b00;
            step(op, arg, bit'((r >> 10) & 1), bit'((r >> 11) & 1), "R11");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule